// File: doc/BRIEF.md
# Two-Phase Addressed ROM with Window Decode

This block is a 512-word by 8-bit read-only store for a processor that puts its 16-bit address on eight shared lines in two phases. First the high byte is placed on the lines while a strobe is active. The block keeps that byte in an internal register. Then the low byte follows on the same lines. The stored high byte and the live low byte together form the full address.

The block answers only when that address falls inside one 512-word-aligned window of the 64K space. The window is chosen by a base parameter. Two select inputs must also sit at their configured levels. When all of these hold, a chip-enable output goes high so that other memory on the bus stays quiet. If the active-low read strobe is also low, the block raises its data output enable and presents the addressed word. The word contents come from a fixed formula of the index, so no memory file is needed. The strobe level and each select level are set by parameters. All outputs are registered on the system clock.

Top module: `paged_rom`

## Requirements
- R1: The word at index i (0..511) is bits 7..0 of ((i*29 + SEED) XOR (i >> 3)), where SEED defaults to 8'h3C. The index is formed from bit 0 of the stored high byte as index bit 8, with the live address lines as bits 7..0.
- R2: The stored high byte takes the value on the address lines at the first clock edge at which the strobe is seen inactive after it was seen active at the previous edge. At every other edge the stored byte keeps its value.
- R3: The strobe counts as active when it equals STRB_LEVEL (default 1). Holding the strobe at the inactive level never changes the stored byte, whatever the address lines carry.
- R4: The address is in the window when bits 7..1 of the stored high byte equal bits 15..9 of BASE (default 16'h2400, so high bytes 8'h24 and 8'h25 match).
- R5: One clock after an edge, chip_en is 1 exactly when the address was in the window at that edge, sel_a equalled CS1_LEVEL (default 1) and sel_b equalled CS2_LEVEL (default 0). Otherwise chip_en is 0.
- R6: One clock after an edge, data_oe is 1 exactly when the R5 condition held and rd_n was 0 at that edge.
- R7: data_out shows the R1 word of the index at that edge whenever data_oe is 1, and shows 0 whenever data_oe is 0.
- R8: A synchronous reset (rst high at an edge) sets the stored high byte to 0, forgets any pending strobe, and forces chip_en, data_oe and data_out to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_lines | input | 8 | Shared address lines: high byte, then low byte |
| hi_strobe | input | 1 | High-address capture strobe, level set by STRB_LEVEL |
| sel_a | input | 1 | First select, active level CS1_LEVEL |
| sel_b | input | 1 | Second select, active level CS2_LEVEL |
| rd_n | input | 1 | Read strobe, active low |
| data_out | output | 8 | Read data, zero when not driving |
| data_oe | output | 1 | Drive enable for the tri-state data bus |
| chip_en | output | 1 | High while the block is selected |

## Verification
The assertions assume that the strobe and selects are synchronous to the clock and that rd_n is driven to a known level from reset on. The stored-byte hold check also assumes the strobe is inactive during and just after reset. The stimulus changes every input only at falling clock edges and keeps the strobe inactive around each reset. It keeps the high byte on the lines for the edge at which the strobe is first seen released, which is the capture point named in R2. Out-of-window bytes, wrong select levels, a raised read strobe and address changes while the strobe is idle are all driven between ordinary reads.

// File: rtl/paged_rom_pkg.sv
package paged_rom_pkg;

    function automatic logic [31:0] rom_word(input int unsigned idx, input int unsigned seed);
        logic [31:0] v;
        v = 32'(idx * 29 + seed) ^ 32'(idx >> 3);
        return v;
    endfunction

endpackage

// File: rtl/prx_latch.sv
module prx_latch #(
    parameter int   BUS_W      = 8,
    parameter logic STRB_LEVEL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] bus,
    input  logic             strobe,
    output logic [BUS_W-1:0] hi_q
);
    logic             seen_d, seen_q;
    logic [BUS_W-1:0] hi_d;
    logic             active;

    always_comb begin
        active = (strobe == STRB_LEVEL);
        seen_d = active;
        hi_d   = hi_q;
        // capture on the first edge where the strobe is seen released
        if (seen_q && !active) begin
            hi_d = bus;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            hi_q   <= '0;
        end else begin
            seen_q <= seen_d;
            hi_q   <= hi_d;
        end
    end
endmodule

// File: rtl/prx_decode.sv
module prx_decode #(
    parameter int          BUS_W     = 8,
    parameter int          ADDR_W    = 16,
    parameter int          IDX_W     = 9,
    parameter logic [15:0] BASE      = 16'h2400,
    parameter logic        CS1_LEVEL = 1'b1,
    parameter logic        CS2_LEVEL = 1'b0
) (
    input  logic [BUS_W-1:0] hi,
    input  logic             sel_a,
    input  logic             sel_b,
    input  logic             rd_n,
    output logic             selected,
    output logic             reading
);
    localparam int LOW_HI_W = IDX_W - BUS_W;
    localparam int CMP_W    = ADDR_W - IDX_W;
    localparam logic [CMP_W-1:0] WIN = BASE[ADDR_W-1:IDX_W];

    logic in_win;

    always_comb begin
        in_win   = (hi[BUS_W-1:LOW_HI_W] == WIN);
        selected = in_win && (sel_a == CS1_LEVEL) && (sel_b == CS2_LEVEL);
        reading  = selected && !rd_n;
    end
endmodule

// File: rtl/prx_rom.sv
module prx_rom #(
    parameter int          IDX_W  = 9,
    parameter int          DATA_W = 8,
    parameter int unsigned SEED   = 32'h3C
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] word
);
    import paged_rom_pkg::*;

    logic [31:0] full;

    always_comb begin
        full = rom_word(32'(idx), SEED);
        word = full[DATA_W-1:0];
    end
endmodule

// File: rtl/paged_rom.sv
module paged_rom #(
    parameter int          BUS_W      = 8,
    parameter int          ADDR_W     = 16,
    parameter int          DEPTH      = 512,
    parameter int          DATA_W     = 8,
    parameter logic [15:0] BASE       = 16'h2400,
    parameter logic        STRB_LEVEL = 1'b1,
    parameter logic        CS1_LEVEL  = 1'b1,
    parameter logic        CS2_LEVEL  = 1'b0,
    parameter int unsigned SEED       = 32'h3C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_W-1:0]  addr_lines,
    input  logic              hi_strobe,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              rd_n,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              chip_en
);
    localparam int IDX_W    = $clog2(DEPTH);
    localparam int LOW_HI_W = IDX_W - BUS_W;

    typedef struct packed {
        logic              ce;
        logic              oe;
        logic [DATA_W-1:0] data;
    } out_t;

    logic [BUS_W-1:0]  hi_q;
    logic              selected, reading;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] word;
    out_t              out_d, out_q;

    prx_latch #(.BUS_W(BUS_W), .STRB_LEVEL(STRB_LEVEL)) u_latch (
        .clk(clk), .rst(rst), .bus(addr_lines), .strobe(hi_strobe), .hi_q(hi_q)
    );

    prx_decode #(
        .BUS_W(BUS_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE(BASE),
        .CS1_LEVEL(CS1_LEVEL), .CS2_LEVEL(CS2_LEVEL)
    ) u_decode (
        .hi(hi_q), .sel_a(sel_a), .sel_b(sel_b), .rd_n(rd_n),
        .selected(selected), .reading(reading)
    );

    assign idx = {hi_q[LOW_HI_W-1:0], addr_lines};

    prx_rom #(.IDX_W(IDX_W), .DATA_W(DATA_W), .SEED(SEED)) u_rom (
        .idx(idx), .word(word)
    );

    always_comb begin
        out_d.ce   = selected;
        out_d.oe   = reading;
        out_d.data = reading ? word : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign chip_en  = out_q.ce;
    assign data_oe  = out_q.oe;
    assign data_out = out_q.data;
endmodule

// File: rtl/paged_rom_chk.sv
module paged_rom_chk #(
    parameter int   BUS_W      = 8,
    parameter int   DATA_W     = 8,
    parameter logic STRB_LEVEL = 1'b1,
    parameter logic CS1_LEVEL  = 1'b1,
    parameter logic CS2_LEVEL  = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              hi_strobe,
    input logic              sel_a,
    input logic              sel_b,
    input logic              rd_n,
    input logic [BUS_W-1:0]  hi_q,
    input logic [DATA_W-1:0] data_out,
    input logic              data_oe,
    input logic              chip_en
);
    a_r3_idle_strobe_holds: assert property (@(posedge clk) disable iff (rst)
        ((hi_strobe != STRB_LEVEL) && $past(hi_strobe != STRB_LEVEL)) |=> $stable(hi_q));

    a_r5_ce_needs_selects: assert property (@(posedge clk) disable iff (rst)
        chip_en |-> ($past(sel_a) == CS1_LEVEL && $past(sel_b) == CS2_LEVEL));

    a_r6_oe_needs_read: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> ($past(rd_n) == 1'b0));

    a_r6_oe_within_ce: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> chip_en);

    a_r7_quiet_bus_zero: assert property (@(posedge clk) disable iff (rst)
        !data_oe |-> (data_out == '0));

    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (!chip_en && !data_oe && hi_q == '0));
endmodule

bind paged_rom paged_rom_chk #(
    .BUS_W(BUS_W), .DATA_W(DATA_W), .STRB_LEVEL(STRB_LEVEL),
    .CS1_LEVEL(CS1_LEVEL), .CS2_LEVEL(CS2_LEVEL)
) u_chk (
    .clk(clk), .rst(rst), .hi_strobe(hi_strobe), .sel_a(sel_a), .sel_b(sel_b),
    .rd_n(rd_n), .hi_q(hi_q), .data_out(data_out), .data_oe(data_oe), .chip_en(chip_en)
);

// File: tb/paged_rom_bench.sv
module paged_rom_bench;
    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] BASE  = 16'h2400;
    localparam logic        STRB  = 1'b1;
    localparam logic        CS1   = 1'b1;
    localparam logic        CS2   = 1'b0;
    localparam int          SEED  = 32'h3C;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr_lines = 8'h00;
    logic       hi_strobe = ~STRB;
    logic       sel_a = CS1;
    logic       sel_b = CS2;
    logic       rd_n = 1'b1;
    logic [7:0] data_out;
    logic       data_oe, chip_en;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    // behavioural reference state
    int   m_hi = 0;
    bit   m_prev = 0;
    bit   e_ce = 0, e_oe = 0;
    int   e_data = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    paged_rom #(.BASE(BASE), .STRB_LEVEL(STRB), .CS1_LEVEL(CS1),
                .CS2_LEVEL(CS2), .SEED(SEED)) u_paged_rom (
        .clk(clk), .rst(rst), .addr_lines(addr_lines), .hi_strobe(hi_strobe),
        .sel_a(sel_a), .sel_b(sel_b), .rd_n(rd_n),
        .data_out(data_out), .data_oe(data_oe), .chip_en(chip_en)
    );

    function automatic int word_of(int i);
        return ((i * 29 + SEED) ^ (i >> 3)) & 8'hFF;
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit act_s, win, sel;
        if (rst) begin
            m_hi = 0; m_prev = 0; e_ce = 0; e_oe = 0; e_data = 0;
        end else begin
            act_s = (hi_strobe == STRB);
            win = ((m_hi >> 1) == (BASE >> 9));
            sel = win && sel_a == CS1 && sel_b == CS2;
            e_ce = sel;
            e_oe = sel && !rd_n;
            e_data = e_oe ? word_of(((m_hi & 1) << 8) | addr_lines) : 0;
            if (m_prev && !act_s) m_hi = addr_lines;
            m_prev = act_s;
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            check("R5 chip_en", chip_en, e_ce);
            check("R6 data_oe", data_oe, e_oe);
            check("R7 data_out", data_out, e_data);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic set_hi(logic [7:0] hb);
        @(negedge clk); addr_lines = hb; hi_strobe = STRB;
        @(negedge clk); hi_strobe = ~STRB;
    endtask

    task automatic read_lo(logic [7:0] lb, bit rd, output int d, output bit ce, output bit oe);
        @(negedge clk); addr_lines = lb; rd_n = !rd;
        @(negedge clk); #1; d = data_out; ce = chip_en; oe = data_oe; rd_n = 1'b1;
    endtask

    task automatic access(int a, string tag);
        int d; bit ce, oe;
        set_hi(a[15:8]);
        read_lo(a[7:0], 1, d, ce, oe);
        check({tag, " ce"}, ce, 1);
        check({tag, " word"}, d, word_of(a & 16'h01FF));
    endtask

    initial begin
        int d; bit ce, oe;
        repeat (3) @(negedge clk);
        check("R8 reset ce", chip_en, 0);
        check("R8 reset oe", data_oe, 0);
        check("R8 reset data", data_out, 0);
        @(negedge clk); rst = 1'b0;

        access(16'h2400, "R1 index0");
        access(16'h24FF, "R1 index255");
        access(16'h2500, "R1 index256");
        access(16'h25FF, "R4 top of window");
        for (int k = 0; k < 40; k++) access(16'h2400 + ((k * 53) % 512), "R1 sweep");

        set_hi(8'h26);
        read_lo(8'h00, 1, d, ce, oe);
        check("R4 above window ce", ce, 0);
        check("R4 above window oe", oe, 0);
        set_hi(8'h23);
        read_lo(8'hFF, 1, d, ce, oe);
        check("R4 below window ce", ce, 0);

        set_hi(8'h25);
        read_lo(8'h10, 0, d, ce, oe);
        check("R6 no read ce", ce, 1);
        check("R6 no read oe", oe, 0);
        check("R7 no read data", d, 0);

        @(negedge clk); sel_a = ~CS1;
        read_lo(8'h11, 1, d, ce, oe);
        check("R5 sel_a wrong", ce, 0);
        @(negedge clk); sel_a = CS1; sel_b = ~CS2;
        read_lo(8'h12, 1, d, ce, oe);
        check("R5 sel_b wrong", ce, 0);
        @(negedge clk); sel_b = CS2;

        // strobe idle: lines carry other bytes, stored byte must stay 8'h25
        @(negedge clk); addr_lines = 8'h00;
        @(negedge clk); addr_lines = 8'h77;
        read_lo(8'h20, 1, d, ce, oe);
        check("R3 idle strobe ce", ce, 1);
        check("R2 hold word", d, word_of(9'h120));

        // byte captured at release edge, not the one after
        @(negedge clk); addr_lines = 8'h24; hi_strobe = STRB;
        @(negedge clk); hi_strobe = ~STRB;
        read_lo(8'h05, 1, d, ce, oe);
        check("R2 capture word", d, word_of(9'h005));

        // mid-run reset clears the stored byte
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        read_lo(8'h10, 1, d, ce, oe);
        check("R8 latch cleared ce", ce, 0);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule